// File: doc/BRIEF.md
# Dual-Loop Phase-Frequency Detector with Lock and Test Pin Selector

This block holds the digital phase-frequency detectors for two synthesizer loops (loop A at index 0, loop B at index 1). Each loop compares a reference-divider pulse train with a programmable-divider pulse train. It turns the order of their rising edges into pump-up and pump-down requests for an external charge pump. When neither request is active it raises a high-impedance indication. A per-loop polarity bit swaps the sense of the two requests, so the block suits oscillators whose frequency either rises or falls with tuning voltage.

A lock detector watches each loop's phase-error pulse widths, measured in sampling-clock cycles. It declares lock after enough consecutive narrow comparisons. A single shared output pin shows one of several things, chosen by two lock-select bits and two divider-select bits: a loop's lock indication, the combined lock of both loops, or either loop's raw divider pulses. It can also be held low.

All inputs are synchronous to the sampling clock. A divider pulse is counted on its rising edge.

Top module: `dual_pfd_lock`

## Requirements
- R1: With polarity 1, a rising edge on `fr_in[i]` while the loop is idle raises `pump_up[i]` one cycle later, and it stays high. A later rising edge on `fp_in[i]` raises `pump_dn[i]` one cycle after that edge. Both are high for exactly that one cycle and then both drop. With the edge order reversed, `pump_dn[i]` leads in the same way.
- R2: `pump_hiz[i]` is 1 exactly when neither `pump_up[i]` nor `pump_dn[i]` is 1.
- R3: With polarity 0, the two requests of that loop are swapped: the divider-pulse lead drives `pump_up[i]`, and the reference-pulse lead drives `pump_dn[i]`.
- R4: Rising edges on `fr_in[i]` and `fp_in[i]` in the same cycle give a single cycle in which both requests are high. This is the minimum pulse of a locked loop.
- R5: Further edges of the leading input, while the other input's edge is still pending, keep the leading request asserted without a gap. This gives frequency detection across more than one period.
- R6: A comparison ends in the cycle in which both requests are high. Its width is the number of preceding cycles in which exactly one was high. `locked[i]` becomes 1 after LOCK_COUNT consecutive comparisons of width at most LOCK_WIN. A comparison that is wider clears `locked[i]` on the next cycle.
- R7: A loop's lock indication is `locked[i]`, forced low in every cycle in which exactly one of that loop's requests is high. The result is high with narrow low pulses while locked.
- R8: `ldfo` is low when `ld_sel` = 2'b00 and `fo_sel` = 2'b00. It is also low whenever `fo_sel` = 2'b11.
- R9: With `fo_sel` = 2'b00, `ld_sel` = 2'b01 shows loop A's lock indication. 2'b10 shows loop B's. 2'b11 shows the AND of both.
- R10: With `fo_sel` = 2'b01 (loop A) or 2'b10 (loop B), `ldfo` shows that loop's `fr_in` when its own `ld_sel` bit is 0, or its `fp_in` when that bit is 1. The other loop's `ld_sel` bit has no effect.
- R11: `ldfo` is registered, with a one-cycle delay from its selected source. After reset, all requests are 0, `pump_hiz` is all ones, `locked` is 0 and `ldfo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fr_in | input | 2 | Reference-divider pulses, one per loop |
| fp_in | input | 2 | Programmable-divider pulses, one per loop |
| pol | input | 2 | Per-loop polarity: 1 positive, 0 swapped |
| ld_sel | input | 2 | Lock-select bits, bit i for loop i |
| fo_sel | input | 2 | Divider-select bits, bit i for loop i |
| pump_up | output | 2 | Pump-up request per loop |
| pump_dn | output | 2 | Pump-down request per loop |
| pump_hiz | output | 2 | Pump idle (high-impedance) per loop |
| locked | output | 2 | Lock status per loop |
| ldfo | output | 1 | Shared lock/test pin |

## Verification
The detector is driven with reference-leading and divider-leading offsets under both polarities. This separates a correct up/down assignment from a swapped one. Aligned edges exercise the one-cycle minimum pulse. Unequal periods show that a request is held across several leading edges. Aligned and slightly offset trains must bring lock, and a wide offset must drop it, which places the width threshold exactly. All sixteen select combinations are swept while one loop is locked and the other is not. This tells the AND of the two lock indications apart from either single one, and checks that the other loop's lock-select bit has no effect in divider mode.

// File: rtl/pfd_lock_pkg.sv
package pfd_lock_pkg;

   localparam int NUM_LOOPS = 2;

   typedef enum logic [2:0] {
      SRC_LOW,
      SRC_LOCK_A,
      SRC_LOCK_B,
      SRC_LOCK_BOTH,
      SRC_REF_A,
      SRC_DIV_A,
      SRC_REF_B,
      SRC_DIV_B
   } pin_src_e;

   function automatic pin_src_e decode_pin_src(input logic [1:0] ld, input logic [1:0] fo);
      pin_src_e s;
      s = SRC_LOW;
      case (fo)
         2'b00: begin
            case (ld)
               2'b01:   s = SRC_LOCK_A;
               2'b10:   s = SRC_LOCK_B;
               2'b11:   s = SRC_LOCK_BOTH;
               default: s = SRC_LOW;
            endcase
         end
         2'b01:   s = ld[0] ? SRC_DIV_A : SRC_REF_A;
         2'b10:   s = ld[1] ? SRC_DIV_B : SRC_REF_B;
         default: s = SRC_LOW;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/pfd_core.sv
module pfd_core #(
   parameter bit EDGE_IN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fr,
   input  logic fp,
   input  logic polarity,
   output logic up,
   output logic dn,
   output logic pump_hiz,
   output logic ref_q,
   output logic div_q
);

   logic fr_hit;
   logic fp_hit;
   logic both;

   generate
      if (EDGE_IN) begin : g_edge
         logic fr_d;
         logic fp_d;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               fr_d <= 1'b0;
               fp_d <= 1'b0;
            end else begin
               fr_d <= fr;
               fp_d <= fp;
            end
         end
         assign fr_hit = fr & ~fr_d;
         assign fp_hit = fp & ~fp_d;
      end else begin : g_pulse
         assign fr_hit = fr;
         assign fp_hit = fp;
      end
   endgenerate

   assign both = ref_q & div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q <= 1'b0;
         div_q <= 1'b0;
      end else begin
         ref_q <= (ref_q & ~both) | fr_hit;
         div_q <= (div_q & ~both) | fp_hit;
      end
   end

   always_comb begin
      if (polarity) begin
         up = ref_q;
         dn = div_q;
      end else begin
         up = div_q;
         dn = ref_q;
      end
      pump_hiz = ~(up | dn);
   end

   // R1: a new leading edge is captured on the next cycle
   p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fr) |=> ref_q);

   // R5: a pending lead is held until the other edge arrives
   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_q && !div_q) |=> ref_q);

   // R4: both flags clear right after their overlap
   p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (both && !fr_hit) |=> !ref_q);

endmodule

// File: rtl/pfd_lock_det.sv
module pfd_lock_det #(
   parameter int LOCK_WIN   = 2,
   parameter int LOCK_COUNT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_q,
   input  logic div_q,
   output logic locked,
   output logic lock_pin
);

   localparam int WW = $clog2(LOCK_WIN + 2);
   localparam int GW = $clog2(LOCK_COUNT + 1);
   localparam logic [WW-1:0] W_SAT = WW'(LOCK_WIN + 1);
   localparam logic [WW-1:0] W_LIM = WW'(LOCK_WIN);
   localparam logic [GW-1:0] G_MAX = GW'(LOCK_COUNT);

   logic [WW-1:0] width;
   logic [GW-1:0] good;
   logic          both;
   logic          err;
   logic          narrow;

   assign both   = ref_q & div_q;
   assign err    = ref_q ^ div_q;
   assign narrow = (width <= W_LIM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         width <= '0;
         good  <= '0;
      end else if (both) begin
         width <= '0;
         if (narrow) begin
            if (good != G_MAX) good <= good + 1'b1;
         end else begin
            good <= '0;
         end
      end else if (err && (width != W_SAT)) begin
         width <= width + 1'b1;
      end
   end

   assign locked   = (good == G_MAX);
   assign lock_pin = locked & ~err;

   // R6: lock can only appear right after a comparison ends
   p_lock_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(ref_q && div_q));

   // R6: a wide comparison drops lock
   p_lock_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (both && (width > W_LIM)) |=> !locked);

endmodule

// File: rtl/ldfo_mux.sv
module ldfo_mux
   import pfd_lock_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] ld_sel,
   input  logic [1:0] fo_sel,
   input  logic [1:0] lock_pin,
   input  logic [1:0] fr,
   input  logic [1:0] fp,
   output logic       ldfo
);

   pin_src_e src;
   logic     pin_d;

   always_comb begin
      src = decode_pin_src(ld_sel, fo_sel);
      case (src)
         SRC_LOCK_A:    pin_d = lock_pin[0];
         SRC_LOCK_B:    pin_d = lock_pin[1];
         SRC_LOCK_BOTH: pin_d = lock_pin[0] & lock_pin[1];
         SRC_REF_A:     pin_d = fr[0];
         SRC_DIV_A:     pin_d = fp[0];
         SRC_REF_B:     pin_d = fr[1];
         SRC_DIV_B:     pin_d = fp[1];
         default:       pin_d = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ldfo <= 1'b0;
      else        ldfo <= pin_d;
   end

   // R8: disabled selection drives the pin low
   p_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_sel == 2'b00 && fo_sel == 2'b00) |=> !ldfo);

   // R8: both divider-select bits set drives the pin low
   p_fo_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fo_sel == 2'b11) |=> !ldfo);

   // R9: combined lock needs both loops
   p_lock_and_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fo_sel == 2'b00 && ld_sel == 2'b11 && !(lock_pin[0] && lock_pin[1])) |=> !ldfo);

endmodule

// File: rtl/dual_pfd_lock.sv
module dual_pfd_lock
   import pfd_lock_pkg::*;
#(
   parameter int LOCK_WIN   = 2,
   parameter int LOCK_COUNT = 4,
   parameter bit EDGE_IN    = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] fr_in,
   input  logic [1:0] fp_in,
   input  logic [1:0] pol,
   input  logic [1:0] ld_sel,
   input  logic [1:0] fo_sel,
   output logic [1:0] pump_up,
   output logic [1:0] pump_dn,
   output logic [1:0] pump_hiz,
   output logic [1:0] locked,
   output logic       ldfo
);

   generate
      if (LOCK_WIN < 1) begin : g_bad_win
         $error("LOCK_WIN must be at least 1");
      end
      if (LOCK_COUNT < 1) begin : g_bad_cnt
         $error("LOCK_COUNT must be at least 1");
      end
   endgenerate

   logic [NUM_LOOPS-1:0] ref_q;
   logic [NUM_LOOPS-1:0] div_q;
   logic [NUM_LOOPS-1:0] lock_pin;

   generate
      for (genvar i = 0; i < NUM_LOOPS; i++) begin : g_loop
         pfd_core #(.EDGE_IN(EDGE_IN)) u_pfd (
            .clk      (clk),
            .rst_n    (rst_n),
            .fr       (fr_in[i]),
            .fp       (fp_in[i]),
            .polarity (pol[i]),
            .up       (pump_up[i]),
            .dn       (pump_dn[i]),
            .pump_hiz (pump_hiz[i]),
            .ref_q    (ref_q[i]),
            .div_q    (div_q[i])
         );

         pfd_lock_det #(.LOCK_WIN(LOCK_WIN), .LOCK_COUNT(LOCK_COUNT)) u_lock (
            .clk      (clk),
            .rst_n    (rst_n),
            .ref_q    (ref_q[i]),
            .div_q    (div_q[i]),
            .locked   (locked[i]),
            .lock_pin (lock_pin[i])
         );
      end
   endgenerate

   ldfo_mux u_mux (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_sel   (ld_sel),
      .fo_sel   (fo_sel),
      .lock_pin (lock_pin),
      .fr       (fr_in),
      .fp       (fp_in),
      .ldfo     (ldfo)
   );

   // R2: idle indication never coexists with a request
   p_hiz_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(pump_hiz[0] && (pump_up[0] || pump_dn[0])));

endmodule

// File: tb/dual_pfd_lock_test.sv
`timescale 1ns/1ps
module dual_pfd_lock_test;

   localparam int WIN = 2;
   localparam int CNT = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] fr_in = '0, fp_in = '0, pol = '0, ld_sel = '0, fo_sel = '0;
   logic [1:0] pump_up, pump_dn, pump_hiz, locked;
   logic       ldfo;

   dual_pfd_lock #(.LOCK_WIN(WIN), .LOCK_COUNT(CNT)) uut (
      .clk(clk), .rst_n(rst_n), .fr_in(fr_in), .fp_in(fp_in), .pol(pol),
      .ld_sel(ld_sel), .fo_sel(fo_sel), .pump_up(pump_up), .pump_dn(pump_dn),
      .pump_hiz(pump_hiz), .locked(locked), .ldfo(ldfo)
   );

   always #10 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // behavioural model state
   int m_ref[2], m_div[2], m_pfr[2], m_pfp[2], m_w[2], m_good[2];
   int m_ldfo = 0;
   int per_r[2], per_p[2], off[2];
   int cyc = 0;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
      end
   endtask

   function automatic int m_locked(input int i);
      return (m_good[i] >= CNT) ? 1 : 0;
   endfunction

   function automatic int m_lockpin(input int i);
      return (m_locked(i) != 0 && m_ref[i] == m_div[i]) ? 1 : 0;
   endfunction

   function automatic int m_pin();
      int a, b;
      a = m_lockpin(0);
      b = m_lockpin(1);
      if (fo_sel == 2'b00) begin
         if (ld_sel == 2'b01) return a;
         if (ld_sel == 2'b10) return b;
         if (ld_sel == 2'b11) return a & b;
         return 0;
      end
      if (fo_sel == 2'b01) return ld_sel[0] ? int'(fp_in[0]) : int'(fr_in[0]);
      if (fo_sel == 2'b10) return ld_sel[1] ? int'(fp_in[1]) : int'(fr_in[1]);
      return 0;
   endfunction

   task automatic model_edge();
      m_ldfo = m_pin();
      for (int i = 0; i < 2; i++) begin
         int fr_hit, fp_hit;
         if (m_ref[i] == 1 && m_div[i] == 1) begin
            if (m_w[i] <= WIN) m_good[i] = (m_good[i] < CNT) ? m_good[i] + 1 : CNT;
            else m_good[i] = 0;
            m_w[i] = 0;
            m_ref[i] = 0;
            m_div[i] = 0;
         end else if (m_ref[i] != m_div[i]) begin
            m_w[i] = m_w[i] + 1;
         end
         fr_hit = (fr_in[i] && m_pfr[i] == 0) ? 1 : 0;
         fp_hit = (fp_in[i] && m_pfp[i] == 0) ? 1 : 0;
         if (fr_hit != 0) m_ref[i] = 1;
         if (fp_hit != 0) m_div[i] = 1;
         m_pfr[i] = int'(fr_in[i]);
         m_pfp[i] = int'(fp_in[i]);
      end
   endtask

   task automatic compare_all();
      for (int i = 0; i < 2; i++) begin
         int eu, ed;
         eu = pol[i] ? m_ref[i] : m_div[i];
         ed = pol[i] ? m_div[i] : m_ref[i];
         chk($sformatf("R1 R3 R4 R5 pump_up[%0d]", i), int'(pump_up[i]), eu);
         chk($sformatf("R1 R3 R4 R5 pump_dn[%0d]", i), int'(pump_dn[i]), ed);
         chk($sformatf("R2 pump_hiz[%0d]", i), int'(pump_hiz[i]), (eu == 0 && ed == 0) ? 1 : 0);
         chk($sformatf("R6 locked[%0d]", i), int'(locked[i]), m_locked(i));
      end
      chk("R7 R8 R9 R10 R11 ldfo", int'(ldfo), m_ldfo);
   endtask

   task automatic run(input int n);
      for (int k = 0; k < n; k++) begin
         for (int i = 0; i < 2; i++) begin
            fr_in[i] = ((cyc % per_r[i]) == 0);
            fp_in[i] = (((cyc + 100 * per_p[i] - off[i]) % per_p[i]) == 0);
         end
         @(posedge clk);
         model_edge();
         @(negedge clk);
         compare_all();
         cyc++;
      end
   endtask

   task automatic set_loop(input int i, input int pr, input int pp, input int o);
      per_r[i] = pr;
      per_p[i] = pp;
      off[i] = o;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(20 * 50000);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 2; i++) begin
         m_ref[i] = 0; m_div[i] = 0; m_pfr[i] = 0; m_pfp[i] = 0;
         m_w[i] = 0; m_good[i] = 0;
      end
      set_loop(0, 8, 8, 3);
      set_loop(1, 8, 8, -2);
      repeat (3) @(negedge clk);
      // R11: reset state
      chk("R11 pump_up reset", int'(pump_up), 0);
      chk("R11 pump_dn reset", int'(pump_dn), 0);
      chk("R11 pump_hiz reset", int'(pump_hiz), 3);
      chk("R11 locked reset", int'(locked), 0);
      chk("R11 ldfo reset", int'(ldfo), 0);
      rst_n = 1'b1;

      // R1 R3: reference lead on loop A, divider lead on loop B, both polarities
      pol = 2'b11; ld_sel = 2'b00; fo_sel = 2'b00;
      run(48);
      pol = 2'b00;
      run(48);
      pol = 2'b01;
      // R4 R6: aligned edges bring lock
      set_loop(0, 8, 8, 0);
      set_loop(1, 8, 8, 1);
      ld_sel = 2'b11;
      run(80);
      chk("R6 both loops locked", int'(locked), 3);
      // R6: wide offset drops lock on loop A
      set_loop(0, 8, 8, 5);
      run(24);
      chk("R6 loop A unlocked after wide error", int'(locked[0]), 0);
      chk("R6 loop B still locked", int'(locked[1]), 1);
      // R5: unequal periods
      set_loop(0, 10, 13, 0);
      pol = 2'b11;
      run(130);
      set_loop(0, 13, 10, 0);
      run(130);
      // R8 R9 R10: sweep every select code, loop A locked, loop B not
      set_loop(0, 8, 8, 0);
      set_loop(1, 8, 8, 4);
      run(60);
      for (int s = 0; s < 16; s++) begin
         ld_sel = s[1:0];
         fo_sel = s[3:2];
         run(24);
      end
      set_loop(1, 8, 8, 0);
      run(60);
      for (int s = 0; s < 16; s++) begin
         ld_sel = s[1:0];
         fo_sel = s[3:2];
         run(20);
      end
      finish_run();
   end

endmodule